// File: doc/BRIEF.md
# SMBus Block-Read Target with Clock-Low Timeout

This block is the serial-bus side of a management target that answers block-read commands. A controller writes the target address and a command code. It then issues a repeated START and reads back the reply. The reply is a length byte, then that many payload bytes, then an optional packet-error-check byte. Both bus lines are open-drain. The block sees the line levels, and when it wants a line low it raises a drive-low enable. Payload comes from a register file through a request/acknowledge read port indexed by command code and byte position. The target holds SCL low while each byte is being fetched.

When the controller clocks past the last valid byte, the target has nothing left to send. It holds SCL low. A timer in system-clock cycles watches for SCL staying low too long, whoever is holding it. When the limit is reached, the engine abandons the transfer, releases both lines and raises a sticky fault flag. It then stays idle until the next START.

Top module: `smb_blkrd_target`

## Requirements
- R1: After reset both drive-low enables are 0 and the timeout flag is 0.
- R2: The target acknowledges (pulls SDA low in the ninth clock) only an address byte whose upper 7 bits equal parameter ADDR. A read-address byte is acknowledged only after a command byte was taken in the same transfer. After a mismatch it drives SDA for no later byte of that transfer.
- R3: The byte written after the write-address byte is acknowledged and presented on rf_cmd during the read phase. The data returned is the data the register file gives for that code.
- R4: While rf_req is high and rf_ack has not arrived, the target holds SCL low. The controller's next clock therefore waits for the fetch.
- R5: The read phase sends bits MSB first. First comes the count byte (rf_idx = 0, its value taken as the length N), then payload bytes rf_idx = 1..N in order. SDA changes only while SCL is low.
- R6: With pec_en = 1, one more byte follows the payload. It is CRC-8 (polynomial 0x07, seed 0x00, MSB first) over the write-address byte, command byte, read-address byte, count byte and payload bytes. With pec_en = 0 no such byte exists.
- R7: If the controller acknowledges the final byte (payload, or PEC when enabled) and clocks on, the target holds SCL low.
- R8: When SCL has been low for TO_CYC system clocks, both drive-low enables are 0 and to_flag is 1, a few clocks later.
- R9: to_flag stays 1 until to_clr is high for a clock, then reads 0.
- R10: After a timeout, bus activity without a START draws no acknowledge. The next transfer that opens with a START is served normally.
- R11: A NACK from the controller after a read byte ends the read phase. Further clocks before the STOP read all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| pec_en | input | 1 | Append a PEC byte to block reads |
| rf_req | output | 1 | Register-file read request, held until rf_ack |
| rf_idx | output | 8 | Byte position: 0 = length, k = payload byte k |
| rf_cmd | output | 8 | Command code captured from the bus |
| rf_ack | input | 1 | Register-file data valid, one cycle |
| rf_rdata | input | 8 | Register-file read data |
| to_clr | input | 1 | Clear the timeout flag |
| to_flag | output | 1 | Sticky SCL-low timeout flag |

## Verification
A wrong bit count or byte index shows at the ports as a shifted or out-of-order byte, or as a PEC mismatch on the very read it affects. The PEC folds every byte of the transfer, so one lost or duplicated byte spoils the final byte. A wrong end-of-block decision shows within one byte time, either as SCL held early or as an extra byte where the bus should stall. A timer or recovery fault shows TO_CYC clocks after SCL goes low, as a line still held or a flag missing. A stale engine after timeout shows at the next byte as an unwanted acknowledge.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_WAIT, ST_FETCH, ST_TX, ST_RACK, ST_HOLD
    } st_e;

    // one byte through CRC-8, polynomial 0x07, MSB first
    function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] b);
        logic [7:0] c;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            if (c[7] ^ b[i]) c = {c[6:0], 1'b0} ^ 8'h07;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/smb_edges.sv
module smb_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = scl_s;
        sda_d = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign bus_start =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign bus_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/smb_lowtimer.sv
module smb_lowtimer #(
    parameter int TO_CYC = 3_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic bus_stop,
    output logic fire
);
    localparam int TCW = $clog2(TO_CYC + 1);

    logic [TCW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (scl_s || bus_stop)             cnt_d = '0;
        else if (cnt_q != TCW'(TO_CYC))    cnt_d = cnt_q + TCW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // one pulse per low period; the count then parks at the limit
    assign fire = ~scl_s & ~bus_stop & (cnt_q == TCW'(TO_CYC - 1));
endmodule

// File: rtl/smb_blkrd_target.sv
module smb_blkrd_target
    import smb_pkg::*;
#(
    parameter logic [6:0] ADDR   = 7'h42,
    parameter int         TO_CYC = 3_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       pec_en,
    output logic       rf_req,
    output logic [7:0] rf_idx,
    output logic [7:0] rf_cmd,
    input  logic       rf_ack,
    input  logic [7:0] rf_rdata,
    input  logic       to_clr,
    output logic       to_flag
);
    localparam int IW = 9;

    typedef struct packed {
        st_e          st;
        logic [7:0]   sh;
        logic [3:0]   cnt;
        logic         is_cmd;
        logic         rd;
        logic         cmd_ok;
        logic [7:0]   cmd;
        logic [7:0]   len;
        logic [IW-1:0] idx;
        logic [7:0]   crc;
        logic         ack;
        logic         scl_oe;
        logic         sda_oe;
        logic         flag;
    } ctx_t;

    ctx_t d, q;
    logic [1:0] sync_o;
    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop, to_fire;

    smb_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(sync_o)
    );
    assign scl_s = sync_o[1];
    assign sda_s = sync_o[0];

    smb_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    smb_lowtimer #(.TO_CYC(TO_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .bus_stop(bus_stop), .fire(to_fire)
    );

    always_comb begin
        d = q;
        if (to_fire) begin
            d      = '0;
            d.st   = ST_IDLE;
        end else if (bus_start) begin
            d.st     = ST_RX;
            d.cnt    = '0;
            d.is_cmd = 1'b0;
            d.scl_oe = 1'b0;
            d.sda_oe = 1'b0;
        end else if (bus_stop) begin
            d.st     = ST_IDLE;
            d.cmd_ok = 1'b0;
            d.scl_oe = 1'b0;
            d.sda_oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end
                    if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        if (q.is_cmd) begin
                            d.cmd    = q.sh;
                            d.cmd_ok = 1'b1;
                            d.crc    = crc8_byte(q.crc, q.sh);
                            d.rd     = 1'b0;
                            d.st     = ST_ACK;
                            d.sda_oe = 1'b1;
                        end else if (q.sh[7:1] == ADDR && (!q.sh[0] || q.cmd_ok)) begin
                            d.rd     = q.sh[0];
                            d.crc    = crc8_byte(q.sh[0] ? q.crc : 8'h00, q.sh);
                            d.cmd_ok = q.sh[0];
                            d.st     = ST_ACK;
                            d.sda_oe = 1'b1;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        if (q.rd) begin
                            d.st     = ST_FETCH;
                            d.scl_oe = 1'b1;
                            d.idx    = '0;
                        end else if (q.cmd_ok) begin
                            d.st = ST_WAIT;
                        end else begin
                            d.st     = ST_RX;
                            d.is_cmd = 1'b1;
                        end
                    end
                end
                ST_FETCH: begin
                    if (rf_ack) begin
                        d.sh     = rf_rdata;
                        d.crc    = crc8_byte(q.crc, rf_rdata);
                        if (q.idx == '0) d.len = rf_rdata;
                        d.st     = ST_TX;
                        d.cnt    = '0;
                        d.sda_oe = ~rf_rdata[7];
                    end
                end
                ST_TX: begin
                    if (q.scl_oe) begin
                        d.scl_oe = 1'b0;          // data bit set up one clock before release
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.st     = ST_RACK;
                            d.sda_oe = 1'b0;
                        end else begin
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.cnt    = q.cnt + 4'd1;
                            d.sda_oe = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) d.ack = ~sda_s;
                    if (scl_fall) begin
                        if (!q.ack) begin
                            d.st = ST_WAIT;
                        end else begin
                            d.idx = q.idx + IW'(1);
                            if (q.idx < {1'b0, q.len}) begin
                                d.st     = ST_FETCH;
                                d.scl_oe = 1'b1;
                            end else if (q.idx == {1'b0, q.len} && pec_en) begin
                                d.sh     = q.crc;
                                d.st     = ST_TX;
                                d.cnt    = '0;
                                d.sda_oe = ~q.crc[7];
                            end else begin
                                d.st     = ST_HOLD;
                                d.scl_oe = 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
        if (to_fire)     d.flag = 1'b1;
        else if (to_clr) d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign scl_oe  = q.scl_oe;
    assign sda_oe  = q.sda_oe;
    assign rf_req  = (q.st == ST_FETCH);
    assign rf_idx  = q.idx[7:0];
    assign rf_cmd  = q.cmd;
    assign to_flag = q.flag;
endmodule

// File: rtl/smb_chk.sv
module smb_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic rf_req,
    input logic rf_ack,
    input logic to_clr,
    input logic to_flag
);
    // R4: an open fetch keeps SCL low unless a timeout has just released it
    assert_fetch_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req && !rf_ack |=> scl_oe || (to_flag && !$past(to_flag)));

    // R5: SDA drive moves only while SCL is low
    assert_sda_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R8: the cycle the flag rises, both lines are free
    assert_timeout_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> !scl_oe && !sda_oe);

    // R9: flag holds without a clear
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        to_flag && !to_clr |=> to_flag);

    // R9: a clear with no new timeout empties the flag
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        to_clr && to_flag && !scl_oe && scl_i |=> !to_flag || !$past(scl_i));
endmodule

bind smb_blkrd_target smb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rf_req(rf_req), .rf_ack(rf_ack), .to_clr(to_clr), .to_flag(to_flag)
);

// File: tb/sim_smb_blkrd_target.sv
`timescale 1ns/1ps
module sim_smb_blkrd_target;
    localparam logic [6:0] ADDR = 7'h42;
    localparam int TO_CYC = 300;
    localparam int HP     = 20;
    localparam int LIM    = 2000;
    localparam int RF_LAT = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, pec_en = 1'b1, rf_req, rf_ack = 1'b0, to_clr = 1'b0, to_flag;
    logic [7:0] rf_idx, rf_cmd, rf_rdata = 8'h00, len_cfg = 8'd0;
    logic scl_ln, sda_ln;
    int n_chk = 0, n_fail = 0, lat = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz
    assign scl_ln = scl_m & ~scl_oe;
    assign sda_ln = sda_m & ~sda_oe;

    smb_blkrd_target #(.ADDR(ADDR), .TO_CYC(TO_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .pec_en(pec_en),
        .rf_req(rf_req), .rf_idx(rf_idx), .rf_cmd(rf_cmd), .rf_ack(rf_ack),
        .rf_rdata(rf_rdata), .to_clr(to_clr), .to_flag(to_flag)
    );

    function automatic logic [7:0] dat(input logic [7:0] c, input int k);
        return c ^ 8'(k * 29 + 1);
    endfunction

    function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] b);
        logic [8:0] r;
        r = {1'b0, c ^ b};
        for (int i = 0; i < 8; i++) begin
            r = {r[7:0], 1'b0};
            if (r[8]) r = r ^ 9'h107;
        end
        return r[7:0];
    endfunction

    // register-file model: fixed latency, one-cycle acknowledge
    always @(posedge clk) begin
        rf_ack <= 1'b0;
        if (rf_req && !rf_ack) begin
            if (lat == RF_LAT) begin
                rf_ack   <= 1'b1;
                rf_rdata <= (rf_idx == 8'd0) ? len_cfg : dat(rf_cmd, int'(rf_idx));
                lat      <= 0;
            end else lat <= lat + 1;
        end else lat <= 0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_hi(output int w);
        scl_m = 1'b1;
        w = 0;
        @(negedge clk);
        while (!scl_ln && w < LIM) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic bit_cyc(input logic b, output logic s, output int w);
        wt(HP/2); sda_m = b; wt(HP/2);
        clk_hi(w); wt(HP);
        s = sda_ln;
        scl_m = 1'b0;
    endtask

    task automatic gen_start();
        int w;
        wt(HP/2); sda_m = 1'b1; wt(HP/2);
        clk_hi(w); wt(HP);
        sda_m = 1'b0; wt(HP);
        scl_m = 1'b0;
    endtask

    task automatic gen_stop();
        int w;
        wt(HP/2); sda_m = 1'b0; wt(HP/2);
        clk_hi(w); wt(HP);
        sda_m = 1'b1; wt(HP);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        logic s; int w;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], s, w);
        bit_cyc(1'b1, s, w);
        ack = !s;
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] v, output int wmax);
        logic s; int w;
        wmax = 0;
        for (int i = 0; i < 8; i++) begin
            bit_cyc(1'b1, s, w);
            v = {v[6:0], s};
            if (w > wmax) wmax = w;
        end
        bit_cyc(nack, s, w);
    endtask

    task automatic header(input logic [7:0] cmd, output logic [7:0] crc);
        bit a;
        gen_start();
        wbyte({ADDR, 1'b0}, a); chk(a, "R2 write address ack", a, 1);
        wbyte(cmd, a);          chk(a, "R3 command ack", a, 1);
        gen_start();
        wbyte({ADDR, 1'b1}, a); chk(a, "R2 read address ack", a, 1);
        crc = crc_ref(crc_ref(crc_ref(8'h00, {ADDR, 1'b0}), cmd), {ADDR, 1'b1});
    endtask

    // R3 R5 R6: full block read, controller NACKs the last byte
    task automatic t_block(input logic [7:0] cmd, input logic [7:0] n, input logic pe);
        logic [7:0] crc, v; int w; bit last;
        len_cfg = n; pec_en = pe;
        header(cmd, crc);
        rbyte((n == 0 && !pe), v, w);
        chk(v == n, "R5 count byte", v, n);
        chk(w >= 5, "R4 stretch during fetch", w, 5);
        crc = crc_ref(crc, n);
        for (int k = 1; k <= int'(n); k++) begin
            last = (k == int'(n)) && !pe;
            rbyte(last, v, w);
            chk(v == dat(cmd, k), "R5 R3 payload byte", v, dat(cmd, k));
            crc = crc_ref(crc, v);
        end
        if (pe) begin
            rbyte(1'b1, v, w);
            chk(v == crc, "R6 PEC byte", v, crc);
        end
        chk(rf_cmd == cmd, "R3 captured command", rf_cmd, cmd);
        gen_stop();
        chk(!scl_oe && !sda_oe, "R5 lines free after stop", {scl_oe, sda_oe}, 0);
    endtask

    // R6 R7 R8: PEC off, controller ACKs everything and clocks one byte more
    task automatic t_overread();
        logic [7:0] crc, v; int w;
        len_cfg = 8'd2; pec_en = 1'b0;
        header(8'h21, crc);
        rbyte(1'b0, v, w); chk(v == 8'd2, "R5 count byte", v, 2);
        rbyte(1'b0, v, w);
        rbyte(1'b0, v, w); chk(v == dat(8'h21, 2), "R5 last payload", v, dat(8'h21, 2));
        rbyte(1'b0, v, w);
        chk(w > TO_CYC - 100, "R7 SCL held after last byte, no PEC with pec_en=0", w, TO_CYC);
        chk(to_flag, "R8 flag after hold timeout", to_flag, 1);
        chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
        chk(v == 8'hFF, "R8 nothing driven after abort", v, 8'hFF);
        gen_stop();
    endtask

    task automatic t_wrong_addr();
        bit a;
        gen_start();
        wbyte({ADDR ^ 7'h01, 1'b0}, a); chk(!a, "R2 foreign address not acked", a, 0);
        wbyte(8'h42, a);                chk(!a, "R2 no drive after mismatch", a, 0);
        gen_stop();
    endtask

    task automatic t_nack();
        logic [7:0] crc, v; int w;
        len_cfg = 8'd3; pec_en = 1'b1;
        header(8'h11, crc);
        rbyte(1'b1, v, w); chk(v == 8'd3, "R11 count before NACK", v, 3);
        rbyte(1'b1, v, w); chk(v == 8'hFF, "R11 released after NACK", v, 8'hFF);
        gen_stop();
    endtask

    task automatic t_timeout();
        logic s; int w; bit a;
        to_clr = 1'b1; wt(1); to_clr = 1'b0; wt(1);
        chk(!to_flag, "R9 flag cleared", to_flag, 0);
        gen_start();
        for (int i = 0; i < 3; i++) bit_cyc(ADDR[6-i], s, w);
        wt(TO_CYC + 20);
        chk(to_flag, "R8 flag after controller holds SCL", to_flag, 1);
        chk(!scl_oe && !sda_oe, "R8 lines free after timeout", {scl_oe, sda_oe}, 0);
        wbyte({ADDR, 1'b0}, a); chk(!a, "R10 no ack without START", a, 0);
        wbyte(8'h00, a);        chk(!a, "R10 still ignoring bus", a, 0);
        gen_stop();
        chk(to_flag, "R9 flag sticky", to_flag, 1);
        to_clr = 1'b1; wt(1); to_clr = 1'b0; wt(1);
        chk(!to_flag, "R9 flag cleared by to_clr", to_flag, 0);
    endtask

    initial begin
        wt(5);
        chk(!scl_oe && !sda_oe && !to_flag, "R1 reset state", {scl_oe, sda_oe, to_flag}, 0);
        rst_n = 1'b1;
        wt(10);
        t_block(8'h3C, 8'd4, 1'b1);
        t_block(8'h5A, 8'd0, 1'b1);
        t_overread();
        t_wrong_addr();
        t_nack();
        t_block(8'h77, 8'd1, 1'b0);
        t_timeout();
        t_block(8'h09, 8'd2, 1'b1);   // R10 served after START
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule